// File: doc/BRIEF.md
# Consumer Clock Source Selector with Small Divider

The block serves six internal clock consumer ports. Each port picks one of eight source codes: off, the auxiliary PLL, or one of six frequency generators. It divides the chosen source by a small ratio taken from a four-entry table. The sources arrive as single-cycle tick strobes in the system clock domain. Each port returns a divided level signal (`clk_o`) and a strobe (`rise_o`) that marks the start of every output period.

All six ports are configured through one 32-bit control word. Software writes the word whole. Each port also has a disable request and an enable request. A disable request clears the port's source code but remembers it, so that an enable request brings the same source back. Changes to a running port take effect only at the start of its next output period. This keeps a period from being cut short. The divide table has two variants, chosen by a parameter. The extended variant replaces one divide-by-1 entry with divide-by-3.

Top module: `csel_top`

## Requirements
- R1: Port p owns bits 5p+4..5p of the control word. Bits 5p+1..5p hold the divide index and bits 5p+4..5p+2 hold the source code. Bits 31:30 always read as zero. A write appears on `cfg_o` in the cycle after the write strobe.
- R2: Source code 0 means off. Code 1 selects `aux_tick_i`, and codes 2 to 7 select `gen_tick_i[0]` to `gen_tick_i[5]`. A running port advances only on ticks of its own source. Ticks of any other source leave `clk_o` unchanged and produce no `rise_o`.
- R3: With `EXT_DIV3`=0, divide indices 0, 1, 2 and 3 give divisors 1, 4, 1 and 2. An output period lasts that many source ticks.
- R4: With `EXT_DIV3`=1, the table is 1, 4, 3, 2. Divide-by-3 is high for one source tick and low for two.
- R5: For an even divisor N, the output is high for the first N/2 ticks of the period. Divide-by-1 stays high while the port runs.
- R6: A disable request sets the port's source code to 0 and keeps its divide index. An enable request on a port whose source code is 0 restores the last nonzero source code that was written. After reset, that code is 1.
- R7: If a write and a disable request arrive in the same cycle, the write wins. If a disable request and an enable request arrive in the same cycle, the disable wins.
- R8: A change of source code or divide index on a running port takes effect at the tick that starts the port's next output period. The current period finishes with the old settings.
- R9: An off port holds `clk_o` low and never pulses `rise_o`. When a running port is turned off, its output drops at the tick that ends its current period.
- R10: `rise_o` is high for exactly one cycle, in the cycle after the tick that starts a period. `clk_o` changes only in the cycle after a source tick.
- R11: After reset, `cfg_o`, `clk_o` and `rise_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_wdata_i | input | 32 | Control word write data |
| port_dis_i | input | 6 | Per-port disable request |
| port_en_i | input | 6 | Per-port enable request |
| aux_tick_i | input | 1 | Auxiliary PLL tick strobe |
| gen_tick_i | input | 6 | Frequency generator tick strobes |
| cfg_o | output | 32 | Current control word |
| clk_o | output | 6 | Divided per-port outputs |
| rise_o | output | 6 | Per-port period start strobes |

## Verification
A write, disable or enable request is visible on `cfg_o` one cycle after the edge that samples it. A port that is off needs one further cycle to load a new source code before it responds to ticks. `clk_o` and `rise_o` change one cycle after the edge that samples a tick. The bench drives every stimulus on a falling edge, holds it through one rising edge, and samples the outputs at the next falling edge. It also leaves one idle cycle after each configuration change before the first tick. Period, duty, deferred reload and turn-off are each checked tick by tick against a phase count that the bench keeps itself.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned IDX_W   = 2;
  localparam int unsigned FIELD_W = SEL_W + IDX_W;

  // divisor table; ext swaps entry 2 from 1 to 3
  function automatic logic [2:0] div_ratio(input logic [IDX_W-1:0] idx, input logic ext);
    case (idx)
      2'd0:    div_ratio = 3'd1;
      2'd1:    div_ratio = 3'd4;
      2'd2:    div_ratio = ext ? 3'd3 : 3'd1;
      default: div_ratio = 3'd2;
    endcase
  endfunction

  function automatic logic [2:0] high_len(input logic [2:0] n);
    high_len = (n == 3'd1) ? 3'd1 : (n >> 1);
  endfunction
endpackage

// File: rtl/csel_cfg_regs.sv
module csel_cfg_regs
  import csel_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 6,
  parameter int unsigned CFG_W     = 32
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [CFG_W-1:0]                 wdata_i,
  input  logic [NUM_PORTS-1:0]             dis_i,
  input  logic [NUM_PORTS-1:0]             en_i,
  output logic [NUM_PORTS-1:0][SEL_W-1:0]  sel_o,
  output logic [NUM_PORTS-1:0][IDX_W-1:0]  idx_o,
  output logic [CFG_W-1:0]                 cfg_o
);
  localparam logic [SEL_W-1:0] SEL_DEF = SEL_W'(1);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [SEL_W-1:0] sel_q, saved_q;
    logic [IDX_W-1:0] idx_q;
    logic [SEL_W-1:0] w_sel;
    logic [IDX_W-1:0] w_idx;

    assign w_idx = wdata_i[p*FIELD_W +: IDX_W];
    assign w_sel = wdata_i[p*FIELD_W+IDX_W +: SEL_W];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sel_q   <= '0;
        idx_q   <= '0;
        saved_q <= SEL_DEF;
      end else if (we_i) begin
        sel_q <= w_sel;
        idx_q <= w_idx;
        if (w_sel != '0) saved_q <= w_sel;
      end else if (dis_i[p]) begin
        sel_q <= '0;
      end else if (en_i[p] && sel_q == '0) begin
        sel_q <= saved_q;
      end
    end

    assign sel_o[p] = sel_q;
    assign idx_o[p] = idx_q;
  end

  always_comb begin
    cfg_o = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      cfg_o[p*FIELD_W +: IDX_W]       = idx_o[p];
      cfg_o[p*FIELD_W+IDX_W +: SEL_W] = sel_o[p];
    end
  end
endmodule

// File: rtl/csel_port_div.sv
module csel_port_div
  import csel_pkg::*;
#(
  parameter bit EXT_DIV3 = 1'b0,
  localparam int unsigned NSRC = 2**SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   src_tick_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              clk_o,
  output logic              rise_o
);
  logic [SEL_W-1:0] act_sel_q;
  logic [IDX_W-1:0] act_idx_q;
  logic [1:0]       ph_q;
  logic             first_q, out_q, rise_q;

  logic [2:0] n, nm1, ph_nx;
  logic       tick, wrap, running;

  assign n       = div_ratio(act_idx_q, EXT_DIV3);
  assign nm1     = n - 3'd1;
  assign ph_nx   = {1'b0, ph_q} + 3'd1;
  assign running = (act_sel_q != '0);
  assign tick    = running && src_tick_i[act_sel_q];
  assign wrap    = first_q || ({1'b0, ph_q} == nm1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_sel_q <= '0;
      act_idx_q <= '0;
      ph_q      <= '0;
      first_q   <= 1'b1;
      out_q     <= 1'b0;
      rise_q    <= 1'b0;
    end else begin
      rise_q <= 1'b0;
      if (!running) begin
        // idle: track configuration, output low
        act_sel_q <= sel_i;
        act_idx_q <= idx_i;
        ph_q      <= '0;
        first_q   <= 1'b1;
        out_q     <= 1'b0;
      end else if (tick) begin
        if (wrap) begin
          // period boundary: pending settings take effect here
          act_sel_q <= sel_i;
          act_idx_q <= idx_i;
          ph_q      <= '0;
          first_q   <= 1'b0;
          out_q     <= (sel_i != '0);
          rise_q    <= (sel_i != '0);
        end else begin
          ph_q  <= ph_nx[1:0];
          out_q <= (ph_nx < high_len(n));
        end
      end
    end
  end

  assign clk_o  = out_q;
  assign rise_o = rise_q;
endmodule

// File: rtl/csel_top.sv
module csel_top
  import csel_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 6,
  parameter int unsigned NUM_GEN   = 6,
  parameter int unsigned CFG_W     = 32,
  parameter bit          EXT_DIV3  = 1'b0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [CFG_W-1:0]     cfg_wdata_i,
  input  logic [NUM_PORTS-1:0] port_dis_i,
  input  logic [NUM_PORTS-1:0] port_en_i,
  input  logic                 aux_tick_i,
  input  logic [NUM_GEN-1:0]   gen_tick_i,
  output logic [CFG_W-1:0]     cfg_o,
  output logic [NUM_PORTS-1:0] clk_o,
  output logic [NUM_PORTS-1:0] rise_o
);
  localparam int unsigned NSRC = 2**SEL_W;

  logic [NUM_PORTS-1:0][SEL_W-1:0] sel;
  logic [NUM_PORTS-1:0][IDX_W-1:0] idx;
  logic [NSRC-1:0]                 src_vec;

  // code 0 = off, 1 = aux, 2.. = generators
  assign src_vec = NSRC'({gen_tick_i, aux_tick_i, 1'b0});

  csel_cfg_regs #(.NUM_PORTS(NUM_PORTS), .CFG_W(CFG_W)) cfg_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .dis_i   (port_dis_i),
    .en_i    (port_en_i),
    .sel_o   (sel),
    .idx_o   (idx),
    .cfg_o   (cfg_o)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    csel_port_div #(.EXT_DIV3(EXT_DIV3)) div_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .src_tick_i (src_vec),
      .sel_i      (sel[p]),
      .idx_i      (idx[p]),
      .clk_o      (clk_o[p]),
      .rise_o     (rise_o[p])
    );
  end
endmodule

// File: rtl/csel_chk.sv
module csel_chk
  import csel_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 6,
  parameter int unsigned NUM_GEN   = 6,
  parameter int unsigned CFG_W     = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cfg_we_i,
  input logic [CFG_W-1:0]     cfg_wdata_i,
  input logic [NUM_PORTS-1:0] port_dis_i,
  input logic [NUM_PORTS-1:0] port_en_i,
  input logic                 aux_tick_i,
  input logic [NUM_GEN-1:0]   gen_tick_i,
  input logic [CFG_W-1:0]     cfg_o,
  input logic [NUM_PORTS-1:0] clk_o,
  input logic [NUM_PORTS-1:0] rise_o
);
  localparam int unsigned USED = NUM_PORTS * FIELD_W;

  logic any_tick;
  assign any_tick = aux_tick_i || (|gen_tick_i);

  // R7 / R1: a write always lands whole, whatever else is requested
  a_r7_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cfg_we_i) |-> cfg_o[USED-1:0] == $past(cfg_wdata_i[USED-1:0]));

  if (USED < CFG_W) begin : g_rsvd
    a_r1_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_o[CFG_W-1:USED] == '0);
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    a_r6_sel_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(cfg_o[p*FIELD_W+IDX_W +: SEL_W]) |->
        $past(cfg_we_i || port_dis_i[p] || port_en_i[p]));
    a_r10_rise_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[p] |-> clk_o[p]);
    a_r10_rise_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[p] |-> $past(any_tick));
    a_r10_edge_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(clk_o[p]) |-> $past(any_tick));
  end
endmodule

bind csel_top csel_chk #(.NUM_PORTS(NUM_PORTS), .NUM_GEN(NUM_GEN), .CFG_W(CFG_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_wdata_i (cfg_wdata_i),
  .port_dis_i  (port_dis_i),
  .port_en_i   (port_en_i),
  .aux_tick_i  (aux_tick_i),
  .gen_tick_i  (gen_tick_i),
  .cfg_o       (cfg_o),
  .clk_o       (clk_o),
  .rise_o      (rise_o)
);

// File: tb/csel_top_tb_top.sv
module csel_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [5:0]  dis = '0, en = '0;
  logic        aux = 1'b0;
  logic [5:0]  gen = '0;
  logic [31:0] cfg_d, cfg_x;
  logic [5:0]  clk_d, clk_x, rise_d, rise_x;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  csel_top #(.EXT_DIV3(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(we), .cfg_wdata_i(wdata),
    .port_dis_i(dis), .port_en_i(en), .aux_tick_i(aux), .gen_tick_i(gen),
    .cfg_o(cfg_d), .clk_o(clk_d), .rise_o(rise_d));

  csel_top #(.EXT_DIV3(1'b1)) dut_x_i (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(we), .cfg_wdata_i(wdata),
    .port_dis_i(dis), .port_en_i(en), .aux_tick_i(aux), .gen_tick_i(gen),
    .cfg_o(cfg_x), .clk_o(clk_x), .rise_o(rise_x));

  // {port[7:5], source code[4:2], divide index[1:0]}
  localparam logic [7:0] VEC [8] = '{
    {3'd0, 3'd1, 2'd0}, {3'd1, 3'd2, 2'd1}, {3'd2, 3'd3, 2'd2}, {3'd3, 3'd4, 2'd3},
    {3'd4, 3'd7, 2'd2}, {3'd5, 3'd5, 2'd1}, {3'd0, 3'd6, 2'd3}, {3'd5, 3'd1, 2'd2}};

  function automatic int exp_div(input int idx, input bit ext);
    case (idx)
      0: return 1;
      1: return 4;
      2: return ext ? 3 : 1;
      default: return 2;
    endcase
  endfunction

  function automatic int exp_high(input int n);
    return (n == 1) ? 1 : n / 2;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; we = 1'b0; wdata = '0; dis = '0; en = '0; aux = 1'b0; gen = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic ctl(input logic w, input logic [31:0] d, input logic [5:0] ds, input logic [5:0] e);
    @(negedge clk);
    we = w; wdata = d; dis = ds; en = e;
    @(negedge clk);
    we = 1'b0; dis = '0; en = '0;
  endtask

  task automatic pulse_src(input int src);
    @(negedge clk);
    if (src == 1) aux = 1'b1;
    else gen[src-2] = 1'b1;
    @(negedge clk);
    aux = 1'b0; gen = '0;
  endtask

  task automatic pulse_expect(input int src, input int p, input bit c, input bit r, input string req);
    pulse_src(src);
    check(req, {31'd0, clk_d[p]}, {31'd0, c});
    check(req, {31'd0, rise_d[p]}, {31'd0, r});
    check(req, {31'd0, clk_x[p]}, {31'd0, c});
    check(req, {31'd0, rise_x[p]}, {31'd0, r});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    do_reset();
    // R11: reset state
    check("R11 cfg", cfg_d, 32'h0);
    check("R11 clk", {26'd0, clk_d}, 32'h0);
    check("R11 rise", {26'd0, rise_d}, 32'h0);
    // R9: off ports ignore all ticks
    for (int s = 1; s < 8; s++) begin
      pulse_src(s);
      check("R9 off clk", {26'd0, clk_d | clk_x}, 32'h0);
      check("R9 off rise", {26'd0, rise_d | rise_x}, 32'h0);
    end

    // table walk: R2 R3 R4 R5 R10
    for (int v = 0; v < 8; v++) begin
      int p, s, ix, nd, nx;
      p  = int'(VEC[v][7:5]);
      s  = int'(VEC[v][4:2]);
      ix = int'(VEC[v][1:0]);
      nd = exp_div(ix, 1'b0);
      nx = exp_div(ix, 1'b1);
      do_reset();
      ctl(1'b1, 32'(VEC[v][4:0]) << (5 * p), '0, '0);
      check("R1 field", cfg_d, 32'(VEC[v][4:0]) << (5 * p));
      for (int t = 0; t < 12; t++) begin
        bit cd, cx;
        pulse_src(s);
        cd = (t % nd) < exp_high(nd);
        cx = (t % nx) < exp_high(nx);
        check("R3 R5 clk", {31'd0, clk_d[p]}, {31'd0, cd});
        check("R10 rise", {31'd0, rise_d[p]}, {31'd0, (t % nd) == 0});
        check("R4 clk", {31'd0, clk_x[p]}, {31'd0, cx});
        check("R4 rise", {31'd0, rise_x[p]}, {31'd0, (t % nx) == 0});
        pulse_src((s == 1) ? 2 : 1);
        check("R2 other src clk", {31'd0, clk_d[p]}, {31'd0, cd});
        check("R2 other src rise", {31'd0, rise_d[p]}, 32'h0);
        check("R2 other src clk x", {31'd0, clk_x[p]}, {31'd0, cx});
        check("R2 other src rise x", {31'd0, rise_x[p]}, 32'h0);
      end
    end

    // R1: reserved bits
    do_reset();
    ctl(1'b1, 32'hFFFF_FFFF, '0, '0);
    check("R1 rsvd", cfg_d, 32'h3FFF_FFFF);

    // R6: enable after reset restores aux
    do_reset();
    ctl(1'b0, '0, '0, 6'b000001);
    check("R6 default restore", cfg_d, 32'h0000_0004);
    // R6: disable keeps index, enable restores source
    ctl(1'b1, 32'h0000_5C00, '0, '0);
    ctl(1'b0, '0, 6'b000100, '0);
    check("R6 disable", cfg_d, 32'h0000_0C00);
    ctl(1'b0, '0, '0, 6'b000100);
    check("R6 restore", cfg_d, 32'h0000_5C00);
    // R7: priorities
    ctl(1'b1, 32'h0000_6400, 6'b000100, '0);
    check("R7 write over disable", cfg_d, 32'h0000_6400);
    ctl(1'b0, '0, 6'b000100, 6'b000100);
    check("R7 disable over enable", cfg_d, 32'h0000_0400);
    ctl(1'b0, '0, '0, 6'b000100);
    check("R7 restore", cfg_d, 32'h0000_6400);

    // R8: deferred change, then R9 turn-off at boundary
    do_reset();
    ctl(1'b1, 32'h0000_0005, '0, '0);
    pulse_expect(1, 0, 1'b1, 1'b1, "R8 t1");
    pulse_expect(1, 0, 1'b1, 1'b0, "R8 t2");
    ctl(1'b1, 32'h0000_0007, '0, '0);
    pulse_expect(1, 0, 1'b0, 1'b0, "R8 t3 old ratio");
    pulse_expect(1, 0, 1'b0, 1'b0, "R8 t4 old ratio");
    pulse_expect(1, 0, 1'b1, 1'b1, "R8 t5 new ratio");
    pulse_expect(1, 0, 1'b0, 1'b0, "R8 t6");
    pulse_expect(1, 0, 1'b1, 1'b1, "R8 t7");
    pulse_expect(1, 0, 1'b0, 1'b0, "R8 t8");
    ctl(1'b1, 32'h0000_0000, '0, '0);
    pulse_expect(1, 0, 1'b0, 1'b0, "R9 turn off");
    pulse_expect(1, 0, 1'b0, 1'b0, "R9 stays off");
    ctl(1'b0, '0, '0, 6'b000001);
    check("R6 restore last", cfg_d, 32'h0000_0004);
    pulse_expect(1, 0, 1'b1, 1'b1, "R6 restart");
    pulse_expect(1, 0, 1'b1, 1'b1, "R5 div1 high");

    report();
    $finish;
  end
endmodule